// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block owns the command, address and bank-address pins of a low-latency DRAM from reset until the device can accept normal traffic. After reset it keeps the bus idle for a long power-up interval. It then issues a back-to-back burst of mode-register-set commands. All but the last of these are dummies with an all-zero address, and they reset the device's delay-locked loop. The last one places a static configuration word on the address bus. That word selects termination, impedance matching, DLL enable and the row-cycle option.

After a fixed mode-register settle interval, the sequencer refreshes every bank once, in ascending bank order, at a spacing equal to the row-cycle time. The refresh phase has a fixed cycle budget. When that budget runs out, a done flag rises and stays high until the next reset, and the user command path may take the bus.

Every interval is a module parameter, so the power-up wait (200 ms at the target clock by default) can be cut down for simulation. Throughout this brief, "cycle k" means the output values present after the k-th rising clock edge that follows the release of reset.

Top module: `dram_init_seq`

## Requirements
- R1: While reset is high, and for cycles 1 through PWRUP_CYCLES after its release, the command output is NOP (2'b00), address and bank address are zero, and initDone is low.
- R2: Exactly MRS_COUNT mode-register-set commands (encoding 2'b01) appear, on the consecutive cycles PWRUP_CYCLES+1 through PWRUP_CYCLES+MRS_COUNT.
- R3: During every mode-register command except the last, the address and bank address are all zero.
- R4: During the last mode-register command, the address carries cfgWord and the bank address is zero.
- R5: The first refresh appears exactly MRS_SETTLE cycles after the last mode-register command, and every cycle in between is NOP.
- R6: NUM_BANKS refresh commands (encoding 2'b10) are issued with bank addresses 0, 1, … NUM_BANKS-1 in that order, each exactly REF_GAP cycles after the one before, with a zero address.
- R7: Every cycle that carries no mode-register or refresh command drives NOP with a zero address and a zero bank address, and encoding 2'b11 never appears.
- R8: initDone first rises REF_BUDGET cycles after the cycle of the first refresh, stays high with the bus at NOP until reset, and falls on reset.
- R9: A reset asserted part-way through the sequence returns all outputs to the idle state and restarts the whole sequence from the power-up wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgWord | input | ADDR_W | Static configuration word, placed on the address bus by the final mode-register command |
| cmdOut | output | 2 | Command: 00 NOP, 01 mode-register set, 10 refresh |
| addrOut | output | ADDR_W | DRAM address bus |
| baOut | output | BA_W | DRAM bank address, BA_W = clog2(NUM_BANKS) |
| initDone | output | 1 | High once initialization has completed |

## Verification
The bench compares every cycle of a shortened sequence against a cycle model, so any off-by-one at a phase boundary is caught. Such an error would leave the first command one cycle early after the power-up wait, produce nine or eleven mode-register commands, or start the refresh sweep one cycle off the settle time. It also targets the handling of the configuration word. A design that put the word on an early dummy, or left a dummy with a non-zero address, would corrupt the DLL reset or the configuration. The refresh sweep is checked for descending or repeated bank numbers and for spacing that is not the row-cycle time. A mid-sequence reset checks that the counters restart, and the cycles after done checks that the flag stays high and the bus stays quiet.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;

  // Command encoding on cmdOut
  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_MRS = 2'b01,
    CMD_REF = 2'b10
  } cmd_e;

  // Strobes from the sequencing control to the output datapath
  typedef struct packed {
    logic mrsDummy;   // mode-register set, all-zero address
    logic mrsCfg;     // mode-register set carrying the configuration word
    logic refIssue;   // refresh of the next bank in order
    logic doneSet;    // initialization complete
  } strobe_t;

endpackage

// File: rtl/dram_init_ctrl.sv
module dram_init_ctrl
  import dram_init_pkg::*;
#(
  parameter int PWRUP_CYCLES = 40_000_000,
  parameter int MRS_COUNT    = 10,
  parameter int MRS_SETTLE   = 2048,
  parameter int NUM_BANKS    = 8,
  parameter int REF_GAP      = 6,
  parameter int REF_BUDGET   = 6 * 2048
) (
  input  logic    clk,
  input  logic    rst,
  output strobe_t strobe
);

  localparam int SPAN_A   = (PWRUP_CYCLES > MRS_SETTLE) ? PWRUP_CYCLES : MRS_SETTLE;
  localparam int SPAN_B   = (REF_BUDGET > MRS_COUNT) ? REF_BUDGET : MRS_COUNT;
  localparam int MAX_SPAN = (SPAN_A > SPAN_B) ? SPAN_A : SPAN_B;
  localparam int CNT_W    = $clog2(MAX_SPAN + 1);
  localparam int GAP_W    = $clog2(REF_GAP + 1);
  localparam int REFN_W   = $clog2(NUM_BANKS + 1);

  typedef enum logic [2:0] {
    ST_PWRUP, ST_MRS, ST_SETTLE, ST_REF, ST_READY
  } state_e;

  state_e             state;
  logic [CNT_W-1:0]   phaseCnt;
  logic [GAP_W-1:0]   gapCnt;
  logic [REFN_W-1:0]  refsLeft;

  // Strobe decode: one cycle ahead of the registered outputs
  always_comb begin
    strobe = '0;
    unique case (state)
      ST_MRS: begin
        if (phaseCnt == CNT_W'(MRS_COUNT - 1)) strobe.mrsCfg = 1'b1;
        else                                   strobe.mrsDummy = 1'b1;
      end
      ST_REF:   strobe.refIssue = (gapCnt == '0) && (refsLeft != '0);
      ST_READY: strobe.doneSet = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_PWRUP;
      phaseCnt <= '0;
      gapCnt   <= '0;
      refsLeft <= REFN_W'(NUM_BANKS);
    end else begin
      unique case (state)
        ST_PWRUP: begin
          if (phaseCnt == CNT_W'(PWRUP_CYCLES - 1)) begin
            state    <= ST_MRS;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        ST_MRS: begin
          if (phaseCnt == CNT_W'(MRS_COUNT - 1)) begin
            state    <= ST_SETTLE;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        ST_SETTLE: begin
          // MRS_SETTLE-1 idle cycles, so the first refresh lands MRS_SETTLE after the last MRS
          if (phaseCnt == CNT_W'(MRS_SETTLE - 2)) begin
            state    <= ST_REF;
            phaseCnt <= '0;
            gapCnt   <= '0;
            refsLeft <= REFN_W'(NUM_BANKS);
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        ST_REF: begin
          if (strobe.refIssue) begin
            gapCnt   <= GAP_W'(REF_GAP - 1);
            refsLeft <= refsLeft - 1'b1;
          end else if (gapCnt != '0) begin
            gapCnt <= gapCnt - 1'b1;
          end
          if (phaseCnt == CNT_W'(REF_BUDGET - 1)) begin
            state    <= ST_READY;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        default: state <= ST_READY;
      endcase
    end
  end

endmodule

// File: rtl/dram_init_dp.sv
module dram_init_dp
  import dram_init_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int BA_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] cfgWord,
  output logic [1:0]        cmdOut,
  output logic [ADDR_W-1:0] addrOut,
  output logic [BA_W-1:0]   baOut,
  output logic              doneOut
);

  logic [BA_W-1:0] bankNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdOut   <= CMD_NOP;
      addrOut  <= '0;
      baOut    <= '0;
      doneOut  <= 1'b0;
      bankNext <= '0;
    end else begin
      cmdOut  <= CMD_NOP;
      addrOut <= '0;
      baOut   <= '0;
      if (strobe.mrsDummy) begin
        cmdOut <= CMD_MRS;
      end
      if (strobe.mrsCfg) begin
        cmdOut  <= CMD_MRS;
        addrOut <= cfgWord;
      end
      if (strobe.refIssue) begin
        cmdOut   <= CMD_REF;
        baOut    <= bankNext;
        bankNext <= bankNext + 1'b1;
      end
      if (strobe.doneSet) doneOut <= 1'b1;
    end
  end

endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
  import dram_init_pkg::*;
#(
  parameter int ADDR_W       = 22,
  parameter int PWRUP_CYCLES = 40_000_000,
  parameter int MRS_COUNT    = 10,
  parameter int MRS_SETTLE   = 2048,
  parameter int NUM_BANKS    = 8,
  parameter int REF_GAP      = 6,
  parameter int REF_BUDGET   = 6 * 2048,
  localparam int BA_W        = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfgWord,
  output logic [1:0]        cmdOut,
  output logic [ADDR_W-1:0] addrOut,
  output logic [BA_W-1:0]   baOut,
  output logic              initDone
);

  strobe_t strobe;

  dram_init_ctrl #(
    .PWRUP_CYCLES(PWRUP_CYCLES),
    .MRS_COUNT   (MRS_COUNT),
    .MRS_SETTLE  (MRS_SETTLE),
    .NUM_BANKS   (NUM_BANKS),
    .REF_GAP     (REF_GAP),
    .REF_BUDGET  (REF_BUDGET)
  ) ctrl_i (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe)
  );

  dram_init_dp #(
    .ADDR_W(ADDR_W),
    .BA_W  (BA_W)
  ) dp_i (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .cfgWord(cfgWord),
    .cmdOut (cmdOut),
    .addrOut(addrOut),
    .baOut  (baOut),
    .doneOut(initDone)
  );

endmodule

// File: rtl/dram_init_chk.sv
module dram_init_chk #(
  parameter int ADDR_W    = 22,
  parameter int MRS_COUNT = 10,
  parameter int NUM_BANKS = 8,
  parameter int REF_GAP   = 6,
  parameter int BA_W      = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] cfgWord,
  input logic [1:0]        cmdOut,
  input logic [ADDR_W-1:0] addrOut,
  input logic [BA_W-1:0]   baOut,
  input logic              initDone
);

  int mrsSeen;
  int refSeen;
  int sinceRef;

  always_ff @(posedge clk) begin
    if (rst) begin
      mrsSeen  <= 0;
      refSeen  <= 0;
      sinceRef <= 0;
    end else begin
      if (cmdOut == 2'b01 && mrsSeen <= MRS_COUNT) mrsSeen <= mrsSeen + 1;
      if (cmdOut == 2'b10) begin
        refSeen  <= refSeen + 1;
        sinceRef <= 1;
      end else if (sinceRef < 1_000_000) begin
        sinceRef <= sinceRef + 1;
      end
    end
  end

  assert_legal_cmd_R7: assert property (@(posedge clk) disable iff (rst)
    cmdOut != 2'b11);

  assert_idle_bus_R7: assert property (@(posedge clk) disable iff (rst)
    cmdOut == 2'b00 |-> (addrOut == '0 && baOut == '0));

  assert_mrs_count_R2: assert property (@(posedge clk) disable iff (rst)
    cmdOut == 2'b01 |-> mrsSeen < MRS_COUNT);

  assert_mrs_back2back_R2: assert property (@(posedge clk) disable iff (rst)
    (cmdOut == 2'b01 && mrsSeen != 0) |-> $past(cmdOut) == 2'b01);

  assert_dummy_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (cmdOut == 2'b01 && mrsSeen < MRS_COUNT - 1) |-> (addrOut == '0 && baOut == '0));

  assert_cfg_last_R4: assert property (@(posedge clk) disable iff (rst)
    (cmdOut == 2'b01 && mrsSeen == MRS_COUNT - 1) |-> (addrOut == cfgWord && baOut == '0));

  assert_ref_bank_R6: assert property (@(posedge clk) disable iff (rst)
    cmdOut == 2'b10 |-> (int'(baOut) == refSeen && refSeen < NUM_BANKS
                         && mrsSeen == MRS_COUNT && addrOut == '0));

  assert_ref_gap_R6: assert property (@(posedge clk) disable iff (rst)
    (cmdOut == 2'b10 && refSeen != 0) |-> sinceRef == REF_GAP);

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    initDone |=> initDone);

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    initDone |-> (cmdOut == 2'b00 && refSeen == NUM_BANKS));

endmodule

bind dram_init_seq dram_init_chk #(
  .ADDR_W   (ADDR_W),
  .MRS_COUNT(MRS_COUNT),
  .NUM_BANKS(NUM_BANKS),
  .REF_GAP  (REF_GAP),
  .BA_W     (BA_W)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .cfgWord (cfgWord),
  .cmdOut  (cmdOut),
  .addrOut (addrOut),
  .baOut   (baOut),
  .initDone(initDone)
);

// File: tb/dram_init_seq_tb_top.sv
`timescale 1ns/1ps
module dram_init_seq_tb_top;

  localparam int AW   = 16;
  localparam int P    = 20;
  localparam int M    = 10;
  localparam int S    = 16;
  localparam int NB   = 8;
  localparam int G    = 6;
  localparam int B    = 50;
  localparam int FREF = P + M + S;   // cycle of first refresh
  localparam int FDONE = FREF + B;   // first cycle with done high

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] cfgWord = 16'hA5C3;
  logic [1:0]    cmdOut;
  logic [AW-1:0] addrOut;
  logic [2:0]    baOut;
  logic          initDone;

  int edgeCnt;
  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) edgeCnt <= 0;
    else     edgeCnt <= edgeCnt + 1;
  end

  dram_init_seq #(
    .ADDR_W(AW), .PWRUP_CYCLES(P), .MRS_COUNT(M), .MRS_SETTLE(S),
    .NUM_BANKS(NB), .REF_GAP(G), .REF_BUDGET(B)
  ) dut_i (
    .clk(clk), .rst(rst), .cfgWord(cfgWord),
    .cmdOut(cmdOut), .addrOut(addrOut), .baOut(baOut), .initDone(initDone)
  );

  // Milestone vectors: {cycle, cmd, addrIsCfg, bank, done}
  localparam int NMILE = 13;
  localparam logic [14:0] MILES [NMILE] = '{
    {8'd20, 2'b00, 1'b0, 3'd0, 1'b0},
    {8'd21, 2'b01, 1'b0, 3'd0, 1'b0},
    {8'd29, 2'b01, 1'b0, 3'd0, 1'b0},
    {8'd30, 2'b01, 1'b1, 3'd0, 1'b0},
    {8'd31, 2'b00, 1'b0, 3'd0, 1'b0},
    {8'd45, 2'b00, 1'b0, 3'd0, 1'b0},
    {8'd46, 2'b10, 1'b0, 3'd0, 1'b0},
    {8'd47, 2'b00, 1'b0, 3'd0, 1'b0},
    {8'd52, 2'b10, 1'b0, 3'd1, 1'b0},
    {8'd88, 2'b10, 1'b0, 3'd7, 1'b0},
    {8'd94, 2'b00, 1'b0, 3'd0, 1'b0},
    {8'd95, 2'b00, 1'b0, 3'd0, 1'b0},
    {8'd96, 2'b00, 1'b0, 3'd0, 1'b1}
  };

  task automatic check(string tag, logic [1:0] eC, logic [AW-1:0] eA,
                       logic [2:0] eB, logic eD);
    nChecks++;
    if (cmdOut !== eC || addrOut !== eA || baOut !== eB || initDone !== eD) begin
      nFails++;
      $display("FAIL %s cycle %0d: actual cmd=%b addr=%h ba=%0d done=%b expected cmd=%b addr=%h ba=%0d done=%b",
               tag, edgeCnt, cmdOut, addrOut, baOut, initDone, eC, eA, eB, eD);
    end
  endtask

  // Cycle model built from the requirements
  task automatic checkModel(int k);
    logic [1:0] c = 2'b00;
    logic [AW-1:0] a = '0;
    logic [2:0] b = '0;
    logic d = (k >= FDONE);
    string tag = "R7";
    if (k <= P) tag = "R1";
    else if (k <= P + M) begin
      c = 2'b01;
      if (k == P + M) begin a = cfgWord; tag = "R4"; end
      else tag = "R3";
    end else if (k < FREF) tag = "R5";
    else if (k < FDONE) begin
      if ((k - FREF) % G == 0 && (k - FREF) / G < NB) begin
        c = 2'b10; b = 3'((k - FREF) / G); tag = "R6";
      end
    end else tag = "R8";
    check(tag, c, a, b, d);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", 2'b00, '0, 3'd0, 1'b0);
    rst = 1'b0;

    // Full cycle-by-cycle scan of one sequence (R2 count and order included)
    for (int k = 1; k <= FDONE + 14; k++) begin
      @(negedge clk);
      checkModel(edgeCnt);
    end

    // R9: reset part-way, then restart with a new configuration word
    rst = 1'b1;
    @(negedge clk);
    check("R9 reset", 2'b00, '0, 3'd0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 1; k <= 40; k++) @(negedge clk);
    rst = 1'b1;
    cfgWord = 16'h3C5A;
    @(negedge clk);
    check("R9 mid-reset", 2'b00, '0, 3'd0, 1'b0);
    rst = 1'b0;

    // Walk the milestone table on the restarted sequence
    for (int i = 0; i < NMILE; i++) begin
      while (edgeCnt != int'(MILES[i][14:7])) @(negedge clk);
      check("R9 restart", MILES[i][6:5], MILES[i][4] ? cfgWord : '0,
            MILES[i][3:1], MILES[i][0]);
    end

    // R8: done holds with the bus quiet, then falls on reset
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check("R8 hold", 2'b00, '0, 3'd0, 1'b1);
    end
    rst = 1'b1;
    @(negedge clk);
    check("R8 reset", 2'b00, '0, 3'd0, 1'b0);
    finish();
  end

  initial begin
    repeat (5000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual still running, expected finished");
    finish();
  end

endmodule